// File: doc/BRIEF.md
# Instruction Fetch Stage

This block is the first pipeline stage of a small processor. It holds the program counter, picks the address for the next fetch and reads a pair of 16-bit instruction words from a local instruction memory. The address comes from one of two sources. One is a hard-wired zero. The other is a next-PC value that logic outside the stage supplies. A small controller inside the stage picks between them. After a reset, the first fetch always uses address zero. Every later fetch takes the external next-PC value.

For each fetch the stage presents two words: the word at the PC and the word just after it. It also presents the PC itself, with no change, so that the decode stage can work out the following address. Only the low bits of the PC index the memory, so the second word wraps to location 0 when the PC points at the last location. The memory has a write port, and the surrounding system (or a testbench) uses it to load the program before fetching begins.

Top module: `fetch_stage`

## Requirements
- R1: While `rst` is high at a rising edge, then after that edge `fetch_valid` is 0, `pc_out` is 0 and both instruction outputs are 0.
- R2: The first fetch after reset (a rising edge with `fetch_en`=1 and `rst`=0) loads address 0 into the PC, whatever value `next_pc` has.
- R3: Every later fetch loads `next_pc` into the PC, and `pc_out` shows that value with no increment or other change.
- R4: After a fetch at address A, `instr_a` equals memory location A mod DEPTH and `instr_b` equals location (A+1) mod DEPTH. DEPTH-1 wraps to 0.
- R5: `fetch_valid` is 1 exactly in the cycle that follows a rising edge that sampled `fetch_en`=1 and `rst`=0, and is 0 otherwise. The PC and both words change at that same edge.
- R6: A rising edge with `fetch_en`=0 and `rst`=0 leaves `pc_out`, `instr_a` and `instr_b` unchanged.
- R7: Reset has priority over `fetch_en`. A reset applied in mid-run, even with `fetch_en` high, clears the stage, and the next fetch again starts at address 0.
- R8: A rising edge with `load_en`=1 writes `load_data` into location `load_addr`, and a later fetch covering that location returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Perform a fetch at this edge |
| next_pc | input | 16 | Externally computed next fetch address |
| load_en | input | 1 | Instruction memory write strobe |
| load_addr | input | IMEM_AW (8) | Instruction memory write location |
| load_data | input | 16 | Instruction memory write word |
| pc_out | output | 16 | Address of the current fetched pair |
| instr_a | output | 16 | Word at pc_out |
| instr_b | output | 16 | Word at pc_out+1, wrapped |
| fetch_valid | output | 1 | Outputs come from a fetch at the last edge |

## Verification
Suppose the start-up flag inside the controller is wrong. Then the first fetch after a reset shows the external `next_pc` on `pc_out` instead of zero, one cycle after that fetch. If the flag fails to clear, every later fetch sticks at zero. A wrong read address in either memory bank, or a missing wrap, shows up in `instr_a` or `instr_b` in the cycle after the fetch. The bench aims for this with directed fetches at DEPTH-1 and with random addresses whose high bits are set. A PC or a word that drifts while fetching is idle shows up at the very next idle edge.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  // Which source feeds the program counter on a fetch.
  typedef enum logic {
    SRC_ZERO = 1'b0,
    SRC_NEXT = 1'b1
  } pc_src_e;
endpackage

// File: rtl/fetch_seq.sv
// Stage-local sequencer: picks the PC source and issues the load strobe.
module fetch_seq
  import fetch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    fetch_en,
  output pc_src_e pc_src,
  output logic    pc_load
);
  logic boot_q;

  // Armed by reset, consumed by the first fetch.
  always_ff @(posedge clk) begin
    if (rst)           boot_q <= 1'b1;
    else if (fetch_en) boot_q <= 1'b0;
  end

  assign pc_src  = boot_q ? SRC_ZERO : SRC_NEXT;
  assign pc_load = fetch_en && !rst;

  AST_BOOT_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> (pc_src == SRC_NEXT)); // R2
  AST_BOOT_ARMED: assert property (@(posedge clk)
    rst |=> (pc_src == SRC_ZERO)); // R7
endmodule

// File: rtl/fetch_pc.sv
// Next-PC multiplexer and program counter register.
module fetch_pc
  import fetch_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  pc_src_e         src,
  input  logic [PC_W-1:0] next_pc,
  output logic [PC_W-1:0] pc_d,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] PC_ZERO = '0;

  always_comb begin
    unique case (src)
      SRC_ZERO: pc_d = PC_ZERO;
      default:  pc_d = next_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= PC_ZERO;
    else if (load) pc_q <= pc_d;
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(pc_q)); // R6
endmodule

// File: rtl/fetch_imem_bank.sv
// One synchronous-read memory bank with a single write port.
module fetch_imem_bank #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata)); // R6
endmodule

// File: rtl/fetch_stage.sv
// Instruction fetch stage: source select, PC register, paired word read.
module fetch_stage
  import fetch_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int INSTR_W = 16,
  parameter int IMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_en,
  input  logic [PC_W-1:0]    next_pc,
  input  logic               load_en,
  input  logic [IMEM_AW-1:0] load_addr,
  input  logic [INSTR_W-1:0] load_data,
  output logic [PC_W-1:0]    pc_out,
  output logic [INSTR_W-1:0] instr_a,
  output logic [INSTR_W-1:0] instr_b,
  output logic               fetch_valid
);
  localparam int NBANK = 2;

  pc_src_e           src;
  logic              pc_load;
  logic [PC_W-1:0]   pc_d;
  logic [INSTR_W-1:0] rd [NBANK];
  logic              valid_q;

  fetch_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .fetch_en (fetch_en),
    .pc_src   (src),
    .pc_load  (pc_load)
  );

  fetch_pc #(.PC_W(PC_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .load    (pc_load),
    .src     (src),
    .next_pc (next_pc),
    .pc_d    (pc_d),
    .pc_q    (pc_out)
  );

  // Bank g holds a full copy and reads location PC+g (wrapping).
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [IMEM_AW-1:0] raddr;
    assign raddr = pc_d[IMEM_AW-1:0] + IMEM_AW'(g);

    fetch_imem_bank #(.AW(IMEM_AW), .DW(INSTR_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (load_en),
      .waddr (load_addr),
      .wdata (load_data),
      .re    (pc_load),
      .raddr (raddr),
      .rdata (rd[g])
    );
  end

  assign instr_a = rd[0];
  assign instr_b = rd[1];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= fetch_en;
  end
  assign fetch_valid = valid_q;

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!fetch_valid && pc_out == '0)); // R1
  AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> fetch_valid); // R5
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> !fetch_valid); // R5
  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && src == SRC_ZERO) |=> (pc_out == '0)); // R2
  AST_NEXT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && src == SRC_NEXT) |=> (pc_out == $past(next_pc))); // R3
endmodule

// File: tb/fetch_stage_test.sv
`timescale 1ns/1ps
module fetch_stage_test;
  localparam int PC_W = 16;
  localparam int W    = 16;
  localparam int AW   = 8;
  localparam int D    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst, fetch_en, load_en;
  logic [PC_W-1:0] next_pc;
  logic [AW-1:0] load_addr;
  logic [W-1:0]  load_data;
  logic [PC_W-1:0] pc_out;
  logic [W-1:0]  instr_a, instr_b;
  logic          fetch_valid;

  fetch_stage #(.PC_W(PC_W), .INSTR_W(W), .IMEM_AW(AW)) uut (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .next_pc(next_pc),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .pc_out(pc_out), .instr_a(instr_a), .instr_b(instr_b),
    .fetch_valid(fetch_valid));

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Bench model
  logic [W-1:0]    m_mem [D];
  logic [PC_W-1:0] m_pc;
  logic [W-1:0]    m_a, m_b;
  logic            m_valid, m_boot;
  string           pc_tag;

  function automatic logic [W-1:0] pattern(input int a);
    return W'((a * 40503) ^ 23130);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one edge's inputs (called just after a falling edge),
  // advance the model to the state after the next rising edge.
  task automatic drive(input logic r, input logic f, input logic [PC_W-1:0] np,
                       input logic le, input logic [AW-1:0] la, input logic [W-1:0] ld);
    logic [PC_W-1:0] adr;
    rst = r; fetch_en = f; next_pc = np;
    load_en = le; load_addr = la; load_data = ld;
    if (r) begin
      m_pc = '0; m_a = '0; m_b = '0; m_valid = 1'b0; m_boot = 1'b1; pc_tag = "R7";
    end else if (f) begin
      adr = m_boot ? '0 : np;
      pc_tag = m_boot ? "R2" : "R3";
      m_pc = adr;
      m_a = m_mem[adr % D];
      m_b = m_mem[(adr + 1) % D];
      m_valid = 1'b1; m_boot = 1'b0;
    end else begin
      m_valid = 1'b0; pc_tag = "R6";
    end
    if (le) m_mem[la] = ld;
  endtask

  task automatic check_all(input string word_tag);
    chk("R5", 32'(fetch_valid), 32'(m_valid));
    chk(pc_tag, 32'(pc_out), 32'(m_pc));
    chk(word_tag, 32'(instr_a), 32'(m_a));
    chk(word_tag, 32'(instr_b), 32'(m_b));
  endtask

  task automatic step(input logic r, input logic f, input logic [PC_W-1:0] np,
                      input string word_tag);
    drive(r, f, np, 1'b0, '0, '0);
    @(negedge clk);
    check_all(word_tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < D; i++) m_mem[i] = 'x;
    m_boot = 1'b1;
    @(negedge clk);
    // Reset with fetch requested: R1 and R7 priority
    drive(1'b1, 1'b1, 16'h0042, 1'b0, '0, '0);
    @(negedge clk);
    chk("R1", 32'(fetch_valid), 32'd0);
    chk("R1", 32'(pc_out), 32'd0);
    chk("R1", 32'(instr_a), 32'd0);
    chk("R1", 32'(instr_b), 32'd0);
    // Preload memory through the load port (R8), fetch idle
    for (int i = 0; i < D; i++) begin
      drive(1'b0, 1'b0, '0, 1'b1, AW'(i), pattern(i));
      @(negedge clk);
    end
    chk("R6", 32'(pc_out), 32'd0);
    // First fetch ignores next_pc: R2
    step(1'b0, 1'b1, 16'h1234, "R4");
    chk("R2", 32'(pc_out), 32'd0);
    // Directed fetches incl. wrap at DEPTH-1: R4
    step(1'b0, 1'b1, 16'(D - 1), "R4");
    chk("R4", 32'(instr_b), 32'(pattern(0)));
    step(1'b0, 1'b1, 16'hFF05, "R4");
    step(1'b0, 1'b0, 16'h0007, "R6");
    step(1'b0, 1'b0, 16'h0009, "R6");
    // R8: rewrite location 5 then fetch it
    drive(1'b0, 1'b0, '0, 1'b1, AW'(5), 16'hBEEF);
    @(negedge clk);
    check_all("R6");
    step(1'b0, 1'b1, 16'h0005, "R8");
    chk("R8", 32'(instr_a), 32'h0000BEEF);
    // Mid-run reset then restart from zero: R7
    step(1'b1, 1'b1, 16'h0033, "R7");
    step(1'b0, 1'b1, 16'h0033, "R7");
    chk("R7", 32'(pc_out), 32'd0);
    // Random run
    for (int n = 0; n < 2000; n++) begin
      logic r, f;
      logic [PC_W-1:0] np;
      r  = ($urandom_range(0, 49) == 0);
      f  = ($urandom_range(0, 2) != 0);
      np = ($urandom_range(0, 3) == 0) ? 16'(D - 1 + ($urandom_range(0, 1) << 12))
                                       : 16'($urandom);
      step(r, f, np, "R4");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule